// File: doc/BRIEF.md
# Card-Interface PHY Power Sequencer

This block steps the analog front end of a memory-card interface PHY through its power-up and power-down procedure. A power-on request drives power-down-bar and the DLL enable low, then waits a settling interval. It then raises power-down-bar and waits for pad calibration. If calibration succeeds it programs a DLL frequency band taken from the card-clock rate and enables the DLL. Last, it polls the DLL lock indication within a bounded window. A power-off request only drops the two controls and completes at once.

All intervals are given in microseconds and turned into system-clock cycles from the `CLK_HZ` parameter, rounded up and never less than one cycle. A simulation can therefore shrink them by lowering `CLK_HZ` or `LOCK_US`. Requests, status inputs and results are plain level or pulse pins. There is no data stream and so no back-pressure. A request is taken only while the sequencer is idle. The result is reported by a one-cycle `done` pulse together with a held error code.

Top module: `phy_pwr_seq`

## Requirements
- R1: An accepted request drives `pd_n` and `dll_en` low from the next cycle. A power-off request also pulses `done` in that same cycle with `err` = 0 and `busy` low.
- R2: Band code chosen from `rate_hz`: 1..74,999,999 gives 1; 75,000,000..124,999,999 gives 2; 125,000,000..174,999,999 gives 3; 0 or 175,000,000 and above gives 0. The ideal rates are 50, 100, 150 and 200 MHz for codes 1, 2, 3 and 0.
- R3: `rate_warn` is set from the cycle after a power-on is accepted if the rate is above 200 MHz, or if it is above 50 MHz and more than 15 MHz from its band's ideal rate. It never changes the sequence. A power-off request clears it.
- R4: After a power-on is accepted, `pd_n` stays low for SETTLE = ceil(3 us × CLK_HZ) cycles and then rises.
- R5: CAL = ceil(5 us × CLK_HZ) cycles after `pd_n` rises, `cal_done` is sampled. If it is low, `done` pulses with `err` = 1 (calibration timeout), `dll_en` stays low and `freq_sel` is not updated.
- R6: On successful calibration, `freq_sel` takes the band code, and `dll_en` rises one cycle later while `pd_n` is high.
- R7: With a rate of zero, `done` pulses with `err` = 0 in the same cycle that `dll_en` rises, and `dll_ready` is not consulted.
- R8: Otherwise `dll_ready` is sampled every POLL = ceil(1 us × CLK_HZ) cycles, at most LOCK = ceil(LOCK_US / POLL_US) times (LOCK_US defaults to 50,000). The first high sample ends with `err` = 0. If all samples are low, it ends with `err` = 2 (lock timeout).
- R9: Requests that arrive while `busy` is high are ignored and do not change the outputs or the timing.
- R10: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance until the cycle `done` is high. `err` holds until the next accepted request clears it.
- R11: If both requests are high in the same idle cycle, the power-off request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-on request pulse |
| pwr_off_req | input | 1 | Power-off request pulse |
| rate_hz | input | RATE_W | Card-clock rate in Hz, sampled when a power-on is accepted |
| cal_done | input | 1 | Pad calibration complete status |
| dll_ready | input | 1 | DLL lock status |
| pd_n | output | 1 | Power-down-bar to the analog block |
| dll_en | output | 1 | DLL enable |
| freq_sel | output | 2 | DLL frequency band code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 calibration timeout, 2 lock timeout |
| rate_warn | output | 1 | Rate outside the supported window |

## Verification
Power-on runs use rates drawn at random over 0 to 260 MHz, plus the exact band edges and the warning edges: 50 MHz, 65 MHz ± 1 Hz, 200 MHz and 200 MHz + 1 Hz. These separate off-by-one threshold faults in band and warning selection. Runs vary the cycle at which the DLL reports lock: before the first poll, mid-window, on the last poll and never. This tells apart the early-lock, in-window and timeout endings. Calibration failures, a zero rate, stray requests while busy, and simultaneous on/off requests each take a path of their own. Each ending is timed to the exact cycle of every control edge.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_DLL    = 3'd3,
    ST_POLL   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CAL  = 2'd1,
    ERR_LOCK = 2'd2
  } seq_err_e;

  localparam longint unsigned BAND_EDGE_100 = 64'd75_000_000;
  localparam longint unsigned BAND_EDGE_150 = 64'd125_000_000;
  localparam longint unsigned BAND_EDGE_200 = 64'd175_000_000;
  localparam longint unsigned WARN_FLOOR    = 64'd50_000_000;
  localparam longint unsigned WARN_CEIL     = 64'd200_000_000;
  localparam longint unsigned WARN_SPAN     = 64'd15_000_000;

  // microseconds to clock cycles, rounded up, at least one
  function automatic int us_to_cycles(longint hz, longint us);
    longint c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int ceil_div(longint a, longint b);
    longint c;
    c = (a + b - 1) / b;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/phy_band_pick.sv
module phy_band_pick #(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] rate_hz,
  output logic [1:0]        band_code,
  output logic              band_warn
);
  import phy_pwr_pkg::*;

  logic [63:0] r64;
  logic [63:0] ideal;
  logic [63:0] diff;

  always_comb begin
    r64 = 64'(rate_hz);
    if (r64 == 64'd0 || r64 >= BAND_EDGE_200) begin
      band_code = 2'd0;
      ideal     = 64'd200_000_000;
    end else if (r64 >= BAND_EDGE_150) begin
      band_code = 2'd3;
      ideal     = 64'd150_000_000;
    end else if (r64 >= BAND_EDGE_100) begin
      band_code = 2'd2;
      ideal     = 64'd100_000_000;
    end else begin
      band_code = 2'd1;
      ideal     = 64'd50_000_000;
    end
    diff      = (r64 > ideal) ? (r64 - ideal) : (ideal - r64);
    band_warn = (r64 > WARN_CEIL) || ((r64 > WARN_FLOOR) && (diff > WARN_SPAN));
  end

  // R3: any rate above the ceiling falls in band 0 and must warn
  always_comb begin
    if (r64 > WARN_CEIL) begin
      assert_high_rate_R3: assert (band_warn && band_code == 2'd0);
    end
  end

endmodule

// File: rtl/phy_interval_timer.sv
module phy_interval_timer #(
  parameter int MAX_CYC = 1000,
  localparam int TW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R4: a running interval only counts down, never wraps
  assert_timer_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/phy_poll_budget.sv
module phy_poll_budget #(
  parameter int POLLS = 50000,
  localparam int BW = (POLLS < 2) ? 1 : $clog2(POLLS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic last
);
  localparam logic [BW-1:0] LAST_IDX = BW'(POLLS - 1);

  logic [BW-1:0] misses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misses <= '0;
    end else if (clear) begin
      misses <= '0;
    end else if (miss && misses != LAST_IDX) begin
      misses <= misses + 1'b1;
    end
  end

  assign last = (misses == LAST_IDX);

  // R8: the miss count never passes the poll budget
  assert_budget_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misses <= LAST_IDX);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter longint CLK_HZ    = 200_000_000,
  parameter int     SETTLE_US = 3,
  parameter int     CAL_US    = 5,
  parameter int     POLL_US   = 1,
  parameter int     LOCK_US   = 50_000,
  parameter int     RATE_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic [RATE_W-1:0] rate_hz,
  input  logic              cal_done,
  input  logic              dll_ready,
  output logic              pd_n,
  output logic              dll_en,
  output logic [1:0]        freq_sel,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic              rate_warn
);
  import phy_pwr_pkg::*;

  localparam int SETTLE_CYC = us_to_cycles(CLK_HZ, longint'(SETTLE_US));
  localparam int CAL_CYC    = us_to_cycles(CLK_HZ, longint'(CAL_US));
  localparam int POLL_CYC   = us_to_cycles(CLK_HZ, longint'(POLL_US));
  localparam int LOCK_POLLS = ceil_div(longint'(LOCK_US), longint'(POLL_US));
  localparam int MAX_CYC    = (SETTLE_CYC > CAL_CYC) ?
                              ((SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC) :
                              ((CAL_CYC > POLL_CYC) ? CAL_CYC : POLL_CYC);
  localparam int TW         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seq_state_e     state;
  seq_err_e       err_q;
  logic [1:0]     band_code;
  logic           band_warn;
  logic [1:0]     band_q;
  logic           rate_zero;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_expired;
  logic           poll_clear;
  logic           poll_miss;
  logic           poll_last;
  logic           take_on;
  logic           take_off;

  phy_band_pick #(.RATE_W(RATE_W)) band_i (
    .rate_hz   (rate_hz),
    .band_code (band_code),
    .band_warn (band_warn)
  );

  phy_interval_timer #(.MAX_CYC(MAX_CYC)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  phy_poll_budget #(.POLLS(LOCK_POLLS)) budget_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (poll_clear),
    .miss  (poll_miss),
    .last  (poll_last)
  );

  // request acceptance: only when idle, off has priority
  assign take_off = (state == ST_IDLE) && pwr_off_req;
  assign take_on  = (state == ST_IDLE) && pwr_on_req && !pwr_off_req;

  assign poll_clear = (state == ST_DLL);
  assign poll_miss  = (state == ST_POLL) && tmr_expired && !dll_ready;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (take_on) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(CAL_CYC - 1);
      end
      ST_DLL: if (!rate_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(POLL_CYC - 1);
      end
      ST_POLL: if (poll_miss && !poll_last) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(POLL_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pd_n      <= 1'b0;
      dll_en    <= 1'b0;
      freq_sel  <= 2'd0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_q     <= ERR_NONE;
      rate_warn <= 1'b0;
      band_q    <= 2'd0;
      rate_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_off) begin
            pd_n      <= 1'b0;
            dll_en    <= 1'b0;
            done      <= 1'b1;
            err_q     <= ERR_NONE;
            rate_warn <= 1'b0;
          end else if (take_on) begin
            pd_n      <= 1'b0;
            dll_en    <= 1'b0;
            err_q     <= ERR_NONE;
            rate_warn <= band_warn;
            band_q    <= band_code;
            rate_zero <= (rate_hz == '0);
            busy      <= 1'b1;
            state     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_expired) begin
            pd_n  <= 1'b1;
            state <= ST_CAL;
          end
        end
        ST_CAL: begin
          if (tmr_expired) begin
            if (cal_done) begin
              freq_sel <= band_q;
              state    <= ST_DLL;
            end else begin
              err_q <= ERR_CAL;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        ST_DLL: begin
          dll_en <= 1'b1;
          if (rate_zero) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tmr_expired) begin
            if (dll_ready) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else if (poll_last) begin
              err_q <= ERR_LOCK;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign err = err_q;

  // R1: a taken power-off leaves both controls low and completes at once
  assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_off_req) |=> (!pd_n && !dll_en && done && !busy));

  // R1: a sequence starts with both controls low
  assert_on_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!pd_n && !dll_en));

  // R6: the DLL is never enabled while the PHY is powered down
  assert_dll_needs_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en |-> pd_n);

  // R9: a request while busy never restarts the sequence
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pd_n) |=> (pd_n || !busy));

  // R10: completion pulse lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy ends only with a completion
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10: no stale error while a sequence is running
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (err == ERR_NONE));

endmodule

// File: tb/phy_pwr_seq_tb.sv
module phy_pwr_seq_tb_top;

  localparam int S_CYC = 3;
  localparam int C_CYC = 5;
  localparam int L_POLL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on_req = 1'b0;
  logic        pwr_off_req = 1'b0;
  logic [31:0] rate_hz = '0;
  logic        cal_done = 1'b0;
  logic        dll_ready = 1'b0;
  logic        pd_n, dll_en, busy, done, rate_warn;
  logic [1:0]  freq_sel, err;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_freq = 2'd0;

  always #2 clk = ~clk;

  phy_pwr_seq #(
    .CLK_HZ(1_000_000), .SETTLE_US(3), .CAL_US(5), .POLL_US(1),
    .LOCK_US(40), .RATE_W(32)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .rate_hz(rate_hz), .cal_done(cal_done), .dll_ready(dll_ready),
    .pd_n(pd_n), .dll_en(dll_en), .freq_sel(freq_sel), .busy(busy),
    .done(done), .err(err), .rate_warn(rate_warn)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] band_of(input longint r);
    if (r == 0 || r >= 175_000_000) return 2'd0;
    if (r >= 125_000_000) return 2'd3;
    if (r >= 75_000_000) return 2'd2;
    return 2'd1;
  endfunction

  function automatic bit warn_of(input longint r);
    longint ideal, d;
    case (band_of(r))
      2'd1: ideal = 50_000_000;
      2'd2: ideal = 100_000_000;
      2'd3: ideal = 150_000_000;
      default: ideal = 200_000_000;
    endcase
    d = (r > ideal) ? r - ideal : ideal - r;
    return (r > 200_000_000) || (r > 50_000_000 && d > 15_000_000);
  endfunction

  // power-on run; lock_k = bench cycle index after which dll_ready goes high
  task automatic run_on(input longint rate, input bit cal, input int lock_k, input bit poke);
    int k, pd_k, en_k, done_k, exp_done, exp_err, exp_en, first_poll, last_poll;
    logic [1:0] done_err;
    @(negedge clk);
    rate_hz = 32'(rate); cal_done = cal; dll_ready = 1'b0; pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    chk(pd_n == 1'b0 && dll_en == 1'b0, "R1 controls low after on", {pd_n, dll_en}, 0);
    chk(rate_warn == warn_of(rate), "R3 rate warning", rate_warn, warn_of(rate));
    k = 0; pd_k = -1; en_k = -1; done_k = -1; done_err = 2'd3;
    while (k < 400) begin
      if (pd_n && pd_k < 0) pd_k = k;
      if (dll_en && en_k < 0) en_k = k;
      if (done) begin done_k = k; done_err = err; break; end
      if (k == lock_k) dll_ready = 1'b1;
      pwr_off_req = poke && (k == 2 || k == S_CYC + C_CYC);
      pwr_on_req  = poke && (k == 4);
      @(negedge clk);
      k++;
    end
    pwr_off_req = 1'b0; pwr_on_req = 1'b0;
    first_poll = S_CYC + C_CYC + 2;
    last_poll  = S_CYC + C_CYC + 1 + L_POLL;
    exp_en = cal ? S_CYC + C_CYC + 1 : -1;
    if (!cal) begin
      exp_done = S_CYC + C_CYC; exp_err = 1;
    end else if (rate == 0) begin
      exp_done = S_CYC + C_CYC + 1; exp_err = 0;
    end else begin
      exp_done = (lock_k + 1 > first_poll) ? lock_k + 1 : first_poll;
      exp_err = 0;
      if (exp_done > last_poll) begin exp_done = last_poll; exp_err = 2; end
    end
    chk(pd_k == S_CYC, "R4 pd_n rise cycle", pd_k, S_CYC);
    chk(en_k == exp_en, "R6 dll_en rise cycle", en_k, exp_en);
    if (!cal) chk(done_k == exp_done && done_err == 2'(exp_err), "R5 cal timeout", done_err, exp_err);
    else if (rate == 0) chk(done_k == exp_done && done_err == 0, "R7 zero rate end", done_k, exp_done);
    else chk(done_k == exp_done && done_err == 2'(exp_err), "R8 lock end", done_k * 10 + done_err, exp_done * 10 + exp_err);
    if (poke) chk(done_k == exp_done, "R9 busy requests ignored", done_k, exp_done);
    if (cal) exp_freq = band_of(rate);
    chk(freq_sel == exp_freq, "R2 band code", freq_sel, exp_freq);
    chk(busy == 1'b0, "R10 busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(err == 2'(exp_err), "R10 err held", err, exp_err);
    dll_ready = 1'b0;
  endtask

  task automatic run_off(input bit both);
    @(negedge clk);
    pwr_off_req = 1'b1; pwr_on_req = both; rate_hz = 32'd300_000_000;
    @(negedge clk);
    pwr_off_req = 1'b0; pwr_on_req = 1'b0;
    chk(done && !pd_n && !dll_en && !busy && err == 0, "R1 off completes",
        {done, pd_n, dll_en, busy, err}, 6'b100000);
    chk(rate_warn == 1'b0, "R3 warn cleared by off", rate_warn, 0);
    if (both) chk(busy == 1'b0 && pd_n == 1'b0, "R11 off wins", busy, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 no sequence after off", {done, busy}, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint edges [14];
    void'($urandom(32'd20240611));
    edges = '{64'd1, 64'd50_000_000, 64'd65_000_000, 64'd65_000_001, 64'd74_999_999,
              64'd75_000_000, 64'd124_999_999, 64'd125_000_000, 64'd174_999_999,
              64'd175_000_000, 64'd200_000_000, 64'd200_000_001, 64'd35_000_000, 64'd34_999_999};
    repeat (3) @(negedge clk);
    chk(!pd_n && !dll_en && !busy && !done && err == 0 && freq_sel == 0 && !rate_warn,
        "R1 reset state", {pd_n, dll_en, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_on(64'd100_000_000, 1'b1, 0, 1'b0);             // R8 lock before first poll
    run_on(64'd150_000_000, 1'b1, 20, 1'b0);            // R8 mid window
    run_on(64'd60_000_000, 1'b1, S_CYC + C_CYC + L_POLL, 1'b0); // R8 last poll
    run_on(64'd200_000_001, 1'b1, 1000, 1'b0);          // R8 timeout
    run_on(64'd90_000_000, 1'b0, 0, 1'b0);              // R5 cal fail keeps band
    run_on(64'd0, 1'b1, 1000, 1'b0);                    // R7 zero rate
    run_on(64'd130_000_000, 1'b1, 25, 1'b1);            // R9 pokes while busy
    run_off(1'b0);
    run_off(1'b1);
    foreach (edges[i]) run_on(edges[i], 1'b1, 12, 1'b0);
    // constrained random
    for (int it = 0; it < 30; it++) begin
      longint r;
      int lk;
      bit c;
      r  = ($urandom % 8 == 0) ? 64'd0 : longint'($urandom % 260_000_000);
      c  = ($urandom % 8) != 0;
      lk = int'($urandom % 60);
      run_on(r, c, lk, ($urandom % 4) == 0);
      if (($urandom % 5) == 0) run_off(1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule